// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address. It reads two levels of page tables held in ordinary memory. The requester supplies a logical address together with the base address of the root table.

The walker first reads one word from the outer table. If that word is marked valid, it points to an inner table page. The walker then reads one word from that inner page, and that word holds the frame number. An entry marked invalid at either level ends the walk with a fault. The fault response names the level that failed and carries back the logical address that caused it.

The walker has three interfaces. Requests and responses each use a valid/ready handshake. Memory is reached through a single read port with its own handshake. The walker keeps at most one memory read in flight and serves one translation at a time.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: req_ready is 1, rsp_valid is 0 and mem_rd_valid is 0.
- R2: A request is taken only while req_ready is high, which is the idle state. While a walk is in progress req_ready stays low, and any request presented meanwhile is ignored. The response therefore carries the logical address of the request that was taken, in rsp_vaddr.
- R3: The first read goes to the outer table. Its address is req_root plus four times the top 10 bits of the logical address, bits 31:22.
- R4: The second read goes to the inner table. Its address is the outer entry's bits 31:12 followed by 12 zero bits, plus four times logical address bits 21:12.
- R5: Both entries can be valid, meaning bit 0 of each is 1. In that case the response has rsp_fault = 0 and rsp_paddr = {inner entry bits 31:12, logical address bits 11:0}.
- R6: If the outer entry has bit 0 = 0, the walk ends without a second read. The response has rsp_fault = 1, rsp_fault_inner = 0 and rsp_paddr = 0.
- R7: If the inner entry has bit 0 = 0, the response has rsp_fault = 1, rsp_fault_inner = 1 and rsp_paddr = 0.
- R8: Once mem_rd_valid is raised, it stays high and mem_rd_addr stays unchanged until a cycle in which mem_rd_ready is high.
- R9: The response outputs stay valid and unchanged until rsp_ready is high. The walker returns to idle in the following cycle.
- R10: At most one memory read is outstanding. No new read is issued before the response to the previous one has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Logical address to translate |
| req_root | input | 32 | Byte address of the outer table |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_fault | output | 1 | Walk ended on an invalid entry |
| rsp_fault_inner | output | 1 | Fault came from the inner level |
| rsp_paddr | output | 32 | Physical address (zero on fault) |
| rsp_vaddr | output | 32 | Logical address of the walk |
| mem_rd_valid | output | 1 | Read request to memory |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Table entry returned |

## Verification
The assertions assume that memory returns exactly one response for each accepted read. That response must arrive no earlier than the cycle after the acceptance, and memory must never respond with no read pending. The bench memory model keeps to this. It answers each accepted read once, after a random delay of one to three cycles. Its ready signal toggles at random, so the hold rule on the read port is exercised. Table contents come from a hash of the address, with directed entries overriding it for the fault and carry cases.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic [2*IDX_W+OFF_W-1:0]        req_vaddr,
  input  logic [2*IDX_W+OFF_W-1:0]        req_root,
  output logic                            rsp_valid,
  input  logic                            rsp_ready,
  output logic                            rsp_fault,
  output logic                            rsp_fault_inner,
  output logic [2*IDX_W+OFF_W-1:0]        rsp_paddr,
  output logic [2*IDX_W+OFF_W-1:0]        rsp_vaddr,
  output logic                            mem_rd_valid,
  input  logic                            mem_rd_ready,
  output logic [2*IDX_W+OFF_W-1:0]        mem_rd_addr,
  input  logic                            mem_rsp_valid,
  input  logic [2*IDX_W+OFF_W-1:0]        mem_rsp_data
);
  localparam int VA_W = 2*IDX_W + OFF_W;
  localparam int FR_W = VA_W - OFF_W;

  typedef enum logic [2:0] {S_IDLE, S_READ_OUTER, S_READ_INNER, S_DONE, S_FAULT} walk_t;

  walk_t             state;
  logic [VA_W-1:0]   va_q, root_q;
  logic [FR_W-1:0]   base_q;
  logic              sent, lvl;

  wire reading = (state == S_READ_OUTER) || (state == S_READ_INNER);
  wire [VA_W-1:0] outer_addr = root_q + VA_W'({va_q[VA_W-1 -: IDX_W], 2'b00});
  wire [VA_W-1:0] inner_addr = {base_q, {OFF_W{1'b0}}} + VA_W'({va_q[OFF_W +: IDX_W], 2'b00});
  wire entry_ok = mem_rsp_data[0];

  assign req_ready       = (state == S_IDLE);
  assign mem_rd_valid    = reading && !sent;
  assign mem_rd_addr     = (state == S_READ_OUTER) ? outer_addr : inner_addr;
  assign rsp_valid       = (state == S_DONE) || (state == S_FAULT);
  assign rsp_fault       = (state == S_FAULT);
  assign rsp_fault_inner = (state == S_FAULT) && lvl;
  assign rsp_paddr       = (state == S_DONE) ? {base_q, va_q[OFF_W-1:0]} : '0;
  assign rsp_vaddr       = va_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      va_q   <= '0;
      root_q <= '0;
      base_q <= '0;
      sent   <= 1'b0;
      lvl    <= 1'b0;
    end else begin
      case (state)
        S_IDLE:
          if (req_valid) begin
            va_q   <= req_vaddr;
            root_q <= req_root;
            sent   <= 1'b0;
            state  <= S_READ_OUTER;
          end
        S_READ_OUTER, S_READ_INNER:
          if (mem_rd_valid && mem_rd_ready) begin
            sent <= 1'b1;
          end else if (sent && mem_rsp_valid) begin
            sent <= 1'b0;
            lvl  <= (state == S_READ_INNER);
            if (!entry_ok) begin
              state <= S_FAULT;
            end else begin
              base_q <= mem_rsp_data[VA_W-1:OFF_W];
              state  <= (state == S_READ_OUTER) ? S_READ_INNER : S_DONE;
            end
          end
        S_DONE, S_FAULT:
          if (rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic        rsp_fault,
  input logic        rsp_fault_inner,
  input logic [31:0] rsp_paddr,
  input logic [31:0] rsp_vaddr,
  input logic        mem_rd_valid,
  input logic        mem_rd_ready,
  input logic [31:0] mem_rd_addr,
  input logic        mem_rsp_valid
);
  logic outst;
  always_ff @(posedge clk) begin
    if (!rst_n) outst <= 1'b0;
    else if (mem_rd_valid && mem_rd_ready) outst <= 1'b1;
    else if (mem_rsp_valid) outst <= 1'b0;
  end

  a_r8_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)
                                && $stable(rsp_fault_inner) && $stable(rsp_vaddr));

  a_r9_back_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready |=> req_ready);

  a_r10_one_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !outst);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid && !mem_rd_valid);

  a_r5_offset: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_paddr[11:0] == rsp_vaddr[11:0]);
endmodule

bind pt_walker pt_walker_chk chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_fault(rsp_fault), .rsp_fault_inner(rsp_fault_inner),
  .rsp_paddr(rsp_paddr), .rsp_vaddr(rsp_vaddr), .mem_rd_valid(mem_rd_valid),
  .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/pt_walker_test.sv
module pt_walker_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_vaddr = '0, req_root = '0;
  logic        rsp_valid, rsp_ready = 1'b0, rsp_fault, rsp_fault_inner;
  logic [31:0] rsp_paddr, rsp_vaddr;
  logic        mem_rd_valid, mem_rd_ready = 1'b0;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  pt_walker uut (.*);

  int checks = 0, errors = 0;
  bit [31:0] ovr [bit [31:0]];
  bit [31:0] exp_a [2];
  int rd_idx = 0;

  function automatic bit [31:0] word(bit [31:0] a);
    bit [31:0] h;
    if (ovr.exists(a)) return ovr[a];
    h = (a * 32'h9E3779B1) ^ (a >> 7);
    return {h[31:12], 11'b0, (h[7:4] != 4'd0)};
  endfunction

  task automatic chk(string req, bit [31:0] act, bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin : mem_model
    bit pend = 0;
    int lat = 0;
    bit [31:0] pa = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (lat == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = word(pa);
          pend = 0;
        end else lat--;
      end
      mem_rd_ready = ($urandom_range(0, 2) != 0);
      if (rst_n && mem_rd_valid && mem_rd_ready) begin
        pend = 1;
        pa   = mem_rd_addr;
        lat  = $urandom_range(0, 2);
        if (rd_idx > 1) chk("R6", 32'd1, 32'd0);
        else chk(rd_idx == 0 ? "R3" : "R4", mem_rd_addr, exp_a[rd_idx]);
        rd_idx++;
      end
    end
  end

  task automatic walk(bit [31:0] va, bit [31:0] root);
    bit [31:0] w1, w2, epa, s_pa, s_va;
    bit ef, elvl, s_f, s_l;
    int nreads;
    exp_a[0] = root + {20'b0, va[31:22], 2'b00};
    w1 = word(exp_a[0]);
    exp_a[1] = {w1[31:12], 12'b0} + {20'b0, va[21:12], 2'b00};
    w2 = word(exp_a[1]);
    ef = !w1[0] || !w2[0];
    elvl = w1[0];
    epa = ef ? 32'h0 : {w2[31:12], va[11:0]};
    nreads = w1[0] ? 2 : 1;
    rd_idx = 0;
    @(negedge clk);
    chk("R2", {31'b0, req_ready}, 32'd1);
    req_valid = 1'b1; req_vaddr = va; req_root = root;
    @(negedge clk);
    req_vaddr = ~va; req_root = root ^ 32'h0001_0000;
    chk("R2", {31'b0, req_ready}, 32'd0);
    while (!rsp_valid) @(negedge clk);
    req_valid = 1'b0;
    chk("R2", rsp_vaddr, va);
    chk(ef ? (elvl ? "R7" : "R6") : "R5", {30'b0, rsp_fault, rsp_fault_inner}, {30'b0, ef, ef && elvl});
    chk(ef ? "R6" : "R5", rsp_paddr, epa);
    chk("R6", rd_idx, nreads);
    s_pa = rsp_paddr; s_va = rsp_vaddr; s_f = rsp_fault; s_l = rsp_fault_inner;
    repeat ($urandom_range(1, 3)) @(negedge clk);
    chk("R9", {rsp_paddr ^ s_pa} | {rsp_vaddr ^ s_va} | {31'b0, !rsp_valid}
              | {31'b0, rsp_fault ^ s_f} | {31'b0, rsp_fault_inner ^ s_l}, 32'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R9", {30'b0, rsp_valid, req_ready}, 32'd1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R1", {29'b0, req_ready, rsp_valid, mem_rd_valid}, 32'd4);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {29'b0, req_ready, rsp_valid, mem_rd_valid}, 32'd4);

    ovr[32'h0000_1004] = 32'h0055_5000;
    walk(32'h0040_0123, 32'h0000_1000);
    ovr[32'h0000_2008] = 32'h0003_3001;
    ovr[32'h0003_3014] = 32'h0077_7FFE;
    walk(32'h0080_5ABC, 32'h0000_2000);
    ovr[32'h0000_1FF8] = 32'h1234_5001;
    ovr[32'h1234_5FFC] = 32'hABCD_E001;
    walk(32'hFFFF_FFFF, 32'h0000_0FFC);
    ovr[32'h0000_8000] = 32'h0000_1001;
    ovr[32'h0000_1000] = 32'h0000_0001;
    walk(32'h0000_0000, 32'h0000_8000);

    for (int i = 0; i < 60; i++) begin
      walk($urandom, {$urandom_range(0, 32'hF_FFFF), 12'b0});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule